// File: doc/BRIEF.md
# Raster Sequencer for a Raw-Bayer Pixel Output Bus

This block produces the complete line and frame timing for a camera front end that delivers raw mosaic pixels on a parallel bus, one pixel per clock. Every clock it states whether the sync strobes are active. For each pixel inside the output window it states whether the pixel is image, margin or dark reference. It also gives the window row and column, the colour of the mosaic site and a test-pattern pixel value. The analog array, conversion and gain chain are not part of it. The test pattern stands in for real samples so that downstream capture logic can be brought up against exact timing.

A frame opens with a vertical strobe. A fixed gap in clocks follows before the first line. Every line begins with horizontal blanking, during which the horizontal strobe is high. A few blank slots follow, then the window of image pixels with a margin on both sides, then a few more blank slots. Readout starts at the bottom row of the window and moves upward, left to right within a line. The first and last lines of each frame are dark reference lines. Any lines that the programmed frame length adds beyond them are blank lines that carry only the horizontal strobe.

Software sets the line length as a half count and the frame length in lines. Both settings and the monochrome choice are sampled once, on the last clock of a frame, so a frame is always built with one geometry. The first frame after reset always uses the minimum geometry in colour mode.

Top module: `sensor_frame_timer`

## Requirements
- R1: While reset is held, vsync is 1 and hsync, pix_valid, pix_border and pix_dark are 0, with pix_data 0. After release, vsync stays 1 for VS_GAP clocks, with every other output 0.
- R2: A line of L clocks has hsync high for its first L-(2*GUARD+2*BORDER+IMG_W) clocks. GUARD blank clocks follow, then the IMG_W+2*BORDER window clocks, then GUARD blank clocks.
- R3: The line length L is twice cfg_line_half. A value below the minimum HBLANK_MIN+2*GUARD+2*BORDER+IMG_W is raised to it, and a value above MAX_LINE is lowered to MAX_LINE.
- R4: The frame length is cfg_frame_lines lines, clamped to the range from IMG_H+2*BORDER+2 to MAX_FRAME_LINES. Lines after the trailing dark line carry hsync only.
- R5: Line 0 and line IMG_H+2*BORDER+1 of a frame are dark lines. On their window clocks, pix_dark is 1 and pix_data is DARK_LEVEL.
- R6: pix_valid is 1 only on the IMG_W x IMG_H image pixels. pix_border is 1 only on the BORDER-wide margin of the window around them. The two are never both 1.
- R7: pix_row counts window rows from 0 at frame line 1, which is the bottom row, upward. pix_col counts window columns from 0 at the left. Both are 0 outside the row window.
- R8: On row-window pixels in colour mode, pix_tag is {row[0], col[0]}: 00 blue, 01 green on a blue row, 10 green on a red row, 11 red. Elsewhere it is 00.
- R9: In monochrome mode, pix_tag is 01 on every row-window pixel.
- R10: cfg_line_half, cfg_frame_lines and cfg_mono are sampled only on the last clock of a frame. Changes made during a frame do not affect it. The first frame after reset uses the minimum line, the minimum frame and colour mode.
- R11: On row-window pixels, pix_data is (row+col) modulo 2^PIX_W. On blank and blanking clocks, it is 0.
- R12: vsync and hsync are never both 1. The clock after vsync falls starts a line with hsync high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_line_half | input | LW | Line length in clocks divided by two |
| cfg_frame_lines | input | FW | Lines per frame |
| cfg_mono | input | 1 | Monochrome tagging for the next frame |
| hsync | output | 1 | Horizontal blanking strobe |
| vsync | output | 1 | Frame-start strobe |
| pix_valid | output | 1 | Image pixel qualifier |
| pix_border | output | 1 | Margin pixel flag |
| pix_dark | output | 1 | Dark reference pixel flag |
| pix_row | output | RW | Window row, bottom row is 0 |
| pix_col | output | CW | Window column, left is 0 |
| pix_tag | output | 2 | Mosaic colour code |
| pix_data | output | PIX_W | Test-pattern pixel value |

## Verification
The bench programs settings outside the legal range in both directions, so a design that failed to clamp would give lines or frames of the wrong length and the per-clock compare would drift out of step at once. It also rewrites the settings in the middle of a frame. A design that applied them before the frame ended would change the blanking length within that frame. Monochrome is requested before reset is released, and the first frame must still come out in colour. A design that latched the mode straight out of reset would tag that frame wrongly. Dark, blank and margin lines are checked clock by clock against a model of row and column parity, which exposes row counting from the wrong line or a swapped mosaic phase.

// File: rtl/sensor_tmg_pkg.sv
package sensor_tmg_pkg;

   typedef enum logic [1:0] {
      TAG_B  = 2'b00,
      TAG_GB = 2'b01,
      TAG_GR = 2'b10,
      TAG_R  = 2'b11
   } bayer_tag_e;

   typedef enum logic [1:0] {
      LK_DARK  = 2'b00,
      LK_ROW   = 2'b01,
      LK_BLANK = 2'b10
   } line_kind_e;

endpackage

// File: rtl/sft_line_timer.sv
module sft_line_timer #(
   parameter int LW     = 11,
   parameter int ACT    = 652,
   parameter int GUARD  = 4,
   parameter int WIN    = 644
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [LW-1:0] len_q,
   output logic          hsync,
   output logic          in_win,
   output logic [LW-1:0] wx,
   output logic          line_last
);
   localparam logic [LW-1:0] ACT_L   = LW'(ACT);
   localparam logic [LW-1:0] GUARD_L = LW'(GUARD);
   localparam logic [LW-1:0] WIN_L   = LW'(WIN);

   logic [LW-1:0] hcnt;
   logic [LW-1:0] hb;
   logic [LW-1:0] win_lo;

   assign hb     = len_q - ACT_L;
   assign win_lo = hb + GUARD_L;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
      end else if (!run || line_last) begin
         hcnt <= '0;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_comb begin
      hsync     = run && (hcnt < hb);
      in_win    = run && (hcnt >= win_lo) && (hcnt < win_lo + WIN_L);
      wx        = hcnt - win_lo;
      line_last = run && (hcnt == len_q - 1'b1);
   end

   // R3
   hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt < len_q);

endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
   import sensor_tmg_pkg::*;
#(
   parameter int LW         = 11,
   parameter int FW         = 10,
   parameter int RW         = 9,
   parameter int LINE_MIN   = 772,
   parameter int LINE_MAX   = 1156,
   parameter int LINES_MIN  = 486,
   parameter int LINES_MAX  = 1023,
   parameter int ROWS       = 484,
   parameter int VS_GAP     = 120
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] cfg_line_half,
   input  logic [FW-1:0] cfg_frame_lines,
   input  logic          cfg_mono,
   input  logic          line_last,
   output logic          run,
   output logic          vsync,
   output logic [LW-1:0] len_q,
   output logic          mono_q,
   output line_kind_e    kind,
   output logic [RW-1:0] row
);
   localparam int PCW = $clog2(VS_GAP);
   localparam logic [PCW-1:0] GAP_END = PCW'(VS_GAP - 1);
   localparam logic [FW-1:0]  TRAIL   = FW'(ROWS + 1);

   logic [PCW-1:0] pcnt;
   logic [FW-1:0]  vcnt;
   logic [FW-1:0]  lines_q;
   logic [LW-1:0]  len_nx;
   logic [FW-1:0]  lines_nx;
   logic [LW:0]    dbl;
   logic           frame_end;

   always_comb begin
      dbl = {cfg_line_half, 1'b0};
      if (dbl < (LW+1)'(LINE_MIN)) begin
         len_nx = LW'(LINE_MIN);
      end else if (dbl > (LW+1)'(LINE_MAX)) begin
         len_nx = LW'(LINE_MAX);
      end else begin
         len_nx = dbl[LW-1:0];
      end
      if (cfg_frame_lines < FW'(LINES_MIN)) begin
         lines_nx = FW'(LINES_MIN);
      end else if (cfg_frame_lines > FW'(LINES_MAX)) begin
         lines_nx = FW'(LINES_MAX);
      end else begin
         lines_nx = cfg_frame_lines;
      end
   end

   assign frame_end = run && line_last && (vcnt == lines_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         pcnt    <= '0;
         vcnt    <= '0;
         len_q   <= LW'(LINE_MIN);
         lines_q <= FW'(LINES_MIN);
         mono_q  <= 1'b0;
      end else if (!run) begin
         if (pcnt == GAP_END) begin
            run  <= 1'b1;
            pcnt <= '0;
            vcnt <= '0;
         end else begin
            pcnt <= pcnt + 1'b1;
         end
      end else if (frame_end) begin
         run     <= 1'b0;
         vcnt    <= '0;
         len_q   <= len_nx;
         lines_q <= lines_nx;
         mono_q  <= cfg_mono;
      end else if (line_last) begin
         vcnt <= vcnt + 1'b1;
      end
   end

   always_comb begin
      vsync = !run;
      row   = RW'(vcnt - 1'b1);
      if (vcnt == '0 || vcnt == TRAIL) begin
         kind = LK_DARK;
      end else if (vcnt < TRAIL) begin
         kind = LK_ROW;
      end else begin
         kind = LK_BLANK;
      end
   end

   // R10
   geom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !$past(frame_end)) |-> ($stable(len_q) && $stable(mono_q)));

   // R4
   vcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vcnt < lines_q);

endmodule

// File: rtl/sft_pixel_tag.sv
module sft_pixel_tag
   import sensor_tmg_pkg::*;
#(
   parameter int LW         = 11,
   parameter int RW         = 9,
   parameter int CW         = 10,
   parameter int PIX_W      = 10,
   parameter int IMG_W      = 640,
   parameter int IMG_H      = 480,
   parameter int BORDER     = 2,
   parameter int DARK_LEVEL = 64,
   parameter bit COLOR_EN   = 1'b1
) (
   input  logic             in_win,
   input  logic [LW-1:0]    wx,
   input  line_kind_e       kind,
   input  logic [RW-1:0]    row,
   input  logic             mono,
   output logic             pix_valid,
   output logic             pix_border,
   output logic             pix_dark,
   output logic [RW-1:0]    pix_row,
   output logic [CW-1:0]    pix_col,
   output logic [1:0]       pix_tag,
   output logic [PIX_W-1:0] pix_data
);
   logic          on_row;
   logic [CW-1:0] col;
   logic          edge_px;
   bayer_tag_e    site;

   assign on_row = in_win && (kind == LK_ROW);
   assign col    = CW'(wx);

   always_comb begin
      edge_px = (row < RW'(BORDER)) || (row >= RW'(BORDER + IMG_H)) ||
                (col < CW'(BORDER)) || (col >= CW'(BORDER + IMG_W));
      pix_valid  = on_row && !edge_px;
      pix_border = on_row && edge_px;
      pix_dark   = in_win && (kind == LK_DARK);
      pix_row    = on_row ? row : '0;
      pix_col    = on_row ? col : '0;
      if (on_row) begin
         pix_data = PIX_W'(row) + PIX_W'(col);
      end else if (pix_dark) begin
         pix_data = PIX_W'(DARK_LEVEL);
      end else begin
         pix_data = '0;
      end
   end

   generate
      if (COLOR_EN) begin : g_color
         assign site = mono ? TAG_GB : bayer_tag_e'({row[0], col[0]});
      end else begin : g_mono
         assign site = TAG_GB;
      end
   endgenerate

   assign pix_tag = on_row ? site : TAG_B;

endmodule

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer
   import sensor_tmg_pkg::*;
#(
   parameter int IMG_W           = 640,
   parameter int IMG_H           = 480,
   parameter int BORDER          = 2,
   parameter int GUARD           = 4,
   parameter int HBLANK_MIN      = 120,
   parameter int VS_GAP          = 120,
   parameter int MAX_LINE        = 1156,
   parameter int MAX_FRAME_LINES = 1023,
   parameter int PIX_W           = 10,
   parameter int DARK_LEVEL      = 64,
   parameter bit COLOR_EN        = 1'b1,
   localparam int COLS      = IMG_W + 2*BORDER,
   localparam int ROWS      = IMG_H + 2*BORDER,
   localparam int ACT       = COLS + 2*GUARD,
   localparam int LINE_MIN  = HBLANK_MIN + ACT,
   localparam int LINES_MIN = ROWS + 2,
   localparam int LW        = $clog2(MAX_LINE + 1),
   localparam int FW        = $clog2(MAX_FRAME_LINES + 1),
   localparam int RW        = $clog2(ROWS),
   localparam int CW        = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    cfg_line_half,
   input  logic [FW-1:0]    cfg_frame_lines,
   input  logic             cfg_mono,
   output logic             hsync,
   output logic             vsync,
   output logic             pix_valid,
   output logic             pix_border,
   output logic             pix_dark,
   output logic [RW-1:0]    pix_row,
   output logic [CW-1:0]    pix_col,
   output logic [1:0]       pix_tag,
   output logic [PIX_W-1:0] pix_data
);
   initial begin
      assert (IMG_W % 2 == 0 && MAX_LINE % 2 == 0) else $error("widths must be even");
      assert (MAX_LINE >= LINE_MIN) else $error("MAX_LINE below minimum line");
      assert (MAX_FRAME_LINES >= LINES_MIN) else $error("MAX_FRAME_LINES below minimum");
      assert (VS_GAP >= 2 && HBLANK_MIN >= 1) else $error("gaps too short");
      assert (RW <= FW && PIX_W >= RW && PIX_W >= CW) else $error("width mismatch");
   end

   logic          run;
   logic [LW-1:0] len_q;
   logic          mono_q;
   line_kind_e    kind;
   logic [RW-1:0] row;
   logic          in_win;
   logic [LW-1:0] wx;
   logic          line_last;

   sft_frame_seq #(
      .LW(LW), .FW(FW), .RW(RW),
      .LINE_MIN(LINE_MIN), .LINE_MAX(MAX_LINE),
      .LINES_MIN(LINES_MIN), .LINES_MAX(MAX_FRAME_LINES),
      .ROWS(ROWS), .VS_GAP(VS_GAP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_line_half(cfg_line_half), .cfg_frame_lines(cfg_frame_lines),
      .cfg_mono(cfg_mono), .line_last(line_last),
      .run(run), .vsync(vsync), .len_q(len_q), .mono_q(mono_q),
      .kind(kind), .row(row)
   );

   sft_line_timer #(
      .LW(LW), .ACT(ACT), .GUARD(GUARD), .WIN(COLS)
   ) u_line (
      .clk(clk), .rst_n(rst_n), .run(run), .len_q(len_q),
      .hsync(hsync), .in_win(in_win), .wx(wx), .line_last(line_last)
   );

   sft_pixel_tag #(
      .LW(LW), .RW(RW), .CW(CW), .PIX_W(PIX_W),
      .IMG_W(IMG_W), .IMG_H(IMG_H), .BORDER(BORDER),
      .DARK_LEVEL(DARK_LEVEL), .COLOR_EN(COLOR_EN)
   ) u_tag (
      .in_win(in_win), .wx(wx), .kind(kind), .row(row), .mono(mono_q),
      .pix_valid(pix_valid), .pix_border(pix_border), .pix_dark(pix_dark),
      .pix_row(pix_row), .pix_col(pix_col), .pix_tag(pix_tag),
      .pix_data(pix_data)
   );

   // R12
   sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hsync && vsync));

   // R12
   first_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vsync) |-> hsync);

   // R6
   valid_border_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid && pix_border));

   // R5
   dark_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_dark |-> !(pix_valid || pix_border || hsync));

   // R2
   valid_no_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid || pix_border) |-> !hsync);

   // R9
   mono_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mono_q && (pix_valid || pix_border)) |-> (pix_tag == 2'b01));

endmodule

// File: tb/test_sensor_frame_timer.sv
module test_sensor_frame_timer;
   localparam int IMG_W = 8, IMG_H = 4, BORDER = 2, GUARD = 4;
   localparam int HBLANK_MIN = 120, VS_GAP = 120;
   localparam int MAX_LINE = 180, MAX_FRAME_LINES = 14;
   localparam int PIX_W = 10, DARK_LEVEL = 64;
   localparam int COLS = IMG_W + 2*BORDER, ROWS = IMG_H + 2*BORDER;
   localparam int ACT = COLS + 2*GUARD;
   localparam int LW = $clog2(MAX_LINE + 1), FW = $clog2(MAX_FRAME_LINES + 1);
   localparam int RW = $clog2(ROWS), CW = $clog2(COLS);

   typedef struct {
      bit hs, vs, dv, bd, dk;
      int row, col, tag, data;
      bit mono;
      string req;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic [LW-1:0] cfg_line_half;
   logic [FW-1:0] cfg_frame_lines;
   logic cfg_mono;
   logic hsync, vsync, pix_valid, pix_border, pix_dark;
   logic [RW-1:0] pix_row;
   logic [CW-1:0] pix_col;
   logic [1:0] pix_tag;
   logic [PIX_W-1:0] pix_data;

   exp_t q[$];
   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sensor_frame_timer #(
      .IMG_W(IMG_W), .IMG_H(IMG_H), .BORDER(BORDER), .GUARD(GUARD),
      .HBLANK_MIN(HBLANK_MIN), .VS_GAP(VS_GAP), .MAX_LINE(MAX_LINE),
      .MAX_FRAME_LINES(MAX_FRAME_LINES), .PIX_W(PIX_W), .DARK_LEVEL(DARK_LEVEL)
   ) i_sensor_frame_timer (
      .clk(clk), .rst_n(rst_n), .cfg_line_half(cfg_line_half),
      .cfg_frame_lines(cfg_frame_lines), .cfg_mono(cfg_mono),
      .hsync(hsync), .vsync(vsync), .pix_valid(pix_valid),
      .pix_border(pix_border), .pix_dark(pix_dark), .pix_row(pix_row),
      .pix_col(pix_col), .pix_tag(pix_tag), .pix_data(pix_data)
   );

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         if (fails < 20)
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, expv);
      end
   endtask

   // driver: pushes the expected stream of one frame
   task automatic push_frame(int len, int lines, bit mono, string req);
      int hb = len - ACT;
      for (int k = 0; k < VS_GAP; k++) begin
         exp_t e = '{default: 0, req: req};
         e.vs = 1;
         q.push_back(e);
      end
      for (int l = 0; l < lines; l++) begin
         for (int h = 0; h < len; h++) begin
            exp_t e = '{default: 0, req: req};
            int wx = h - hb - GUARD;
            bit win = (wx >= 0) && (wx < COLS);
            e.mono = mono;
            e.hs = (h < hb);
            if (win && (l == 0 || l == ROWS + 1)) begin
               e.dk = 1;
               e.data = DARK_LEVEL;
            end else if (win && l >= 1 && l <= ROWS) begin
               int r = l - 1;
               bit edg = (r < BORDER) || (r >= BORDER + IMG_H) ||
                         (wx < BORDER) || (wx >= BORDER + IMG_W);
               e.dv = !edg;
               e.bd = edg;
               e.row = r;
               e.col = wx;
               e.tag = mono ? 1 : ((r % 2) * 2 + (wx % 2));
               e.data = (r + wx) % (1 << PIX_W);
            end
            q.push_back(e);
         end
      end
   endtask

   initial begin
      int f1, f2;
      cfg_line_half = 8'd80;
      cfg_frame_lines = 4'd12;
      cfg_mono = 1'b1;
      f1 = VS_GAP + 10 * 140;
      f2 = VS_GAP + 12 * 160;
      // R10: first frame ignores the programmed settings; R3 frame 2 uses them
      push_frame(140, 10, 1'b0, "R10");
      push_frame(160, 12, 1'b1, "R3");
      // R3 clamp high, R4 clamp low
      push_frame(180, 10, 1'b0, "R4");
      // R3 clamp low, R4 clamp high with trailing blank lines
      push_frame(140, 14, 1'b0, "R4");
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(vsync === 1'b1, "R1", "vsync in reset", vsync, 1);
      chk(hsync === 1'b0, "R1", "hsync in reset", hsync, 0);
      chk(pix_valid === 1'b0 && pix_border === 1'b0 && pix_dark === 1'b0,
          "R1", "flags in reset", {pix_valid, pix_border, pix_dark}, 0);
      chk(pix_data === '0, "R1", "data in reset", pix_data, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // monitor
      while (q.size() > 0) begin
         exp_t e;
         #1;
         e = q.pop_front();
         chk(vsync === e.vs, "R12 R1", "vsync", vsync, e.vs);
         chk(hsync === e.hs, $sformatf("R2 %s", e.req), "hsync", hsync, e.hs);
         chk(pix_valid === e.dv, "R6", "pix_valid", pix_valid, e.dv);
         chk(pix_border === e.bd, "R6", "pix_border", pix_border, e.bd);
         chk(pix_dark === e.dk, "R5", "pix_dark", pix_dark, e.dk);
         chk(int'(pix_row) == e.row && !$isunknown(pix_row), "R7", "pix_row", pix_row, e.row);
         chk(int'(pix_col) == e.col && !$isunknown(pix_col), "R7", "pix_col", pix_col, e.col);
         chk(int'(pix_tag) == e.tag && !$isunknown(pix_tag), e.mono ? "R9" : "R8",
             "pix_tag", pix_tag, e.tag);
         chk(int'(pix_data) == e.data && !$isunknown(pix_data), e.dk ? "R5" : "R11",
             "pix_data", pix_data, e.data);
         cyc++;
         // R10: settings rewritten mid-frame must wait for the frame end
         if (cyc == f1 + 300) begin
            cfg_line_half = 8'd200;
            cfg_frame_lines = 4'd3;
            cfg_mono = 1'b0;
         end
         if (cyc == f1 + f2 + 300) begin
            cfg_line_half = 8'd5;
            cfg_frame_lines = 4'd15;
         end
         @(negedge clk);
      end
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired: actual %0d expected %0d items left", q.size(), 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule